// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is one output-compare channel of a 16-bit timer. It contains its own free-running up-counter, which advances on a tick-enable input. It also holds a compare value, which can be double buffered. Whenever the counter reaches the compare value on a tick, the block sets a sticky match flag and updates an output bit according to a 2-bit action mode. Software reaches all of this through an 8-bit register bus. Both 16-bit quantities, the compare value and the counter, are written as a high byte into a shared latch followed by a low byte that commits both bytes in a single cycle.

Software can use a force strobe to apply the selected action to the output bit without any real match. This strobe leaves the flag and the counter alone. Any software write to the counter prevents a match on the next tick, so a counter preset equal to the compare value does not fire. When the mode is not zero, the output bit takes over the pin through an output-enable and value pair that goes to the pin mux.

Register map (byte addresses): 0 counter low, 1 counter high, 2 compare low, 3 compare high, 4 control (bits 1:0 mode, bit 7 force strobe), 5 status (bit 0 flag, bit 1 output bit).

Top module: `ocmp_channel`

## Requirements
- R1: After reset the counter, the compare registers, the flag and the output bit read zero, the mode reads 00, and pin_oe and pin_val are 0.
- R2: A write to address 3 only loads the shared high-byte latch and leaves the compare value unchanged. A later write to address 2 stores {latch, written byte} as the whole 16-bit compare value in one cycle.
- R3: With dbuf_en high, compare writes go to a buffer, and addresses 2/3 read the buffer. The active compare value takes the buffer contents only on a tick while the counter is at 0xFFFF. With dbuf_en low, writes go straight to the active value.
- R4: The counter goes up by one on each cycle with tick_en high and wraps from 0xFFFF to 0. Writing address 1 and then address 0 loads it with {latch, byte}, and this load takes priority over a tick in the same cycle.
- R5: A match happens on a cycle where tick_en is high and the counter equals the active compare value. The flag is set on the following cycle and stays set until software writes a 1 to status bit 0. Without tick_en there is no match.
- R6: On a match the output bit is updated one cycle later according to the mode: 00 no change, 01 toggle, 10 clear, 11 set.
- R7: A control write with bit 7 set applies the action of the mode written in that same byte to the output bit. It does not set the flag and does not change the counter.
- R8: A counter load blocks the match on the next ticked cycle, even when idle cycles without tick_en come in between. A counter value loaded equal to the compare value therefore produces no flag.
- R9: pin_oe is 1 exactly when the mode is nonzero, and pin_val is the output bit. A mode write takes effect on the next cycle, and the output bit keeps its value across mode changes.
- R10: Control reads return the mode in bits 1:0 with bit 7 always 0. Status reads return the flag in bit 0 and the output bit in bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter advance and compare qualifier |
| dbuf_en | input | 1 | Selects double buffering of the compare value |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pin_oe | output | 1 | Output bit owns the pin |
| pin_val | output | 1 | Output bit value for the pin |

## Verification
Register writes are visible on the read port one cycle after the write edge. A match is detected combinationally on the ticked cycle where the counter equals the compare value, and both the flag and the output bit change at the edge that closes that cycle. For a counter loaded to C-2 this means three ticks raise the flag, and two ticks leave it clear. The bench drives every input on the falling edge and reads registers a fraction of the half period later. It counts the ticked edges it issued, so each check falls on the first cycle in which the result is due and never earlier.

// File: rtl/ocmp_pkg.sv
// Package: shared types, address map and the output action function for the
// output-compare channel. Assumes an 8-bit bus and a two-byte counter.
package ocmp_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;

    localparam int CTRL_FORCE_BIT = 7;

    typedef enum logic [1:0] {
        OC_HOLD   = 2'b00,
        OC_TOGGLE = 2'b01,
        OC_CLEAR  = 2'b10,
        OC_SET    = 2'b11
    } oc_mode_e;

    // Next output bit value for a given action mode and current value.
    function automatic logic oc_next(input oc_mode_e m, input logic cur);
        logic r;
        case (m)
            OC_TOGGLE: r = ~cur;
            OC_CLEAR:  r = 1'b0;
            OC_SET:    r = 1'b1;
            default:   r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ocmp_bus_if.sv
// Module: register write decoder. Owns the shared high-byte latch, the mode
// register and the single-cycle strobes for counter load, compare commit,
// force and flag clear. Assumes one write per cycle at most.
module ocmp_bus_if
    import ocmp_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [2*BUS_W-1:0]  wide_data,
    output logic                cnt_load,
    output logic                cmp_commit,
    output logic                force_req,
    output oc_mode_e            force_mode,
    output logic                flag_clr,
    output oc_mode_e            mode
);

    logic [BUS_W-1:0] hi_latch;
    logic             wr_ctrl;

    // Merged 16-bit value from latch and current low byte.
    assign wide_data  = {hi_latch, bus_wdata};

    // Decoded strobes, valid only in the write cycle.
    assign cnt_load   = bus_we && (bus_addr == A_CNT_LO);
    assign cmp_commit = bus_we && (bus_addr == A_CMP_LO);
    assign wr_ctrl    = bus_we && (bus_addr == A_CTRL);
    assign force_req  = wr_ctrl && bus_wdata[CTRL_FORCE_BIT];
    assign force_mode = oc_mode_e'(bus_wdata[1:0]);
    assign flag_clr   = bus_we && (bus_addr == A_STAT) && bus_wdata[0];

    // Shared high-byte latch, loaded by either high-byte address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_latch <= '0;
        end else if (bus_we && (bus_addr == A_CNT_HI || bus_addr == A_CMP_HI)) begin
            hi_latch <= bus_wdata;
        end
    end

    // Mode register, takes effect on the cycle after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= OC_HOLD;
        end else if (wr_ctrl) begin
            mode <= force_mode;
        end
    end

endmodule

// File: rtl/ocmp_counter.sv
// Module: free-running up-counter with software load and a one-tick match
// block armed by every load. Assumes load takes priority over the tick.
module ocmp_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             blk
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Wrap event: a tick taken at the top value with no competing load.
    assign wrap = tick_en && !cnt_load && (cnt == CNT_MAX);

    // Counter: load first, otherwise advance on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_load) begin
            cnt <= load_val;
        end else if (tick_en) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Block flag: armed by a load, consumed by the next ticked cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk <= 1'b0;
        end else if (cnt_load) begin
            blk <= 1'b1;
        end else if (tick_en) begin
            blk <= 1'b0;
        end
    end

endmodule

// File: rtl/ocmp_compare.sv
// Module: compare storage (buffer and active value), match detection and the
// sticky match flag. Assumes dbuf_en is held steady by software while used.
module ocmp_compare #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbuf_en,
    input  logic             tick_en,
    input  logic             commit,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wrap,
    input  logic             blk,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cmp_buf,
    output logic [CNT_W-1:0] cmp_act,
    output logic             match_hit,
    output logic             flag
);

    // Match qualified by tick and by the post-load block.
    assign match_hit = tick_en && !blk && (cnt == cmp_act);

    // Buffer register, written only in double-buffer mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_buf <= '0;
        end else if (commit && dbuf_en) begin
            cmp_buf <= wdata;
        end
    end

    // Active compare value: direct write or reload at counter wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_act <= '0;
        end else if (commit && !dbuf_en) begin
            cmp_act <= wdata;
        end else if (dbuf_en && wrap) begin
            cmp_act <= cmp_buf;
        end
    end

    // Sticky flag: set by a match, cleared by a write of one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (match_hit) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/ocmp_outbit.sv
// Module: output bit register. Applies the mode action on a match or on a
// force strobe; a force uses the mode carried by its own write.
module ocmp_outbit
    import ocmp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     match_hit,
    input  logic     force_req,
    input  oc_mode_e force_mode,
    input  oc_mode_e mode,
    output logic     oc
);

    oc_mode_e act_mode;

    // Mode source for this cycle's action.
    assign act_mode = force_req ? force_mode : mode;

    // Output bit update on match or force, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc <= 1'b0;
        end else if (match_hit || force_req) begin
            oc <= oc_next(act_mode, oc);
        end
    end

endmodule

// File: rtl/ocmp_channel.sv
// Module: top of the output-compare channel. Wires the bus decoder, counter,
// compare unit and output bit, and builds the read-back mux and pin pair.
// Assumes reads have no side effects and are combinational from bus_addr.
module ocmp_channel
    import ocmp_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              dbuf_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              pin_oe,
    output logic              pin_val
);

    localparam int CNT_W = 2 * BUS_W;

    logic [CNT_W-1:0] wide_data;
    logic             cnt_load;
    logic             cmp_commit;
    logic             force_req;
    oc_mode_e         force_mode;
    logic             flag_clr;
    oc_mode_e         mode;
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic             blk;
    logic [CNT_W-1:0] cmp_buf;
    logic [CNT_W-1:0] cmp_act;
    logic [CNT_W-1:0] cmp_view;
    logic             match_hit;
    logic             flag;
    logic             oc;

    ocmp_bus_if #(.BUS_W(BUS_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .wide_data  (wide_data),
        .cnt_load   (cnt_load),
        .cmp_commit (cmp_commit),
        .force_req  (force_req),
        .force_mode (force_mode),
        .flag_clr   (flag_clr),
        .mode       (mode)
    );

    ocmp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .cnt_load (cnt_load),
        .load_val (wide_data),
        .cnt      (cnt),
        .wrap     (wrap),
        .blk      (blk)
    );

    ocmp_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbuf_en   (dbuf_en),
        .tick_en   (tick_en),
        .commit    (cmp_commit),
        .wdata     (wide_data),
        .cnt       (cnt),
        .wrap      (wrap),
        .blk       (blk),
        .flag_clr  (flag_clr),
        .cmp_buf   (cmp_buf),
        .cmp_act   (cmp_act),
        .match_hit (match_hit),
        .flag      (flag)
    );

    ocmp_outbit u_oc (
        .clk        (clk),
        .rst_n      (rst_n),
        .match_hit  (match_hit),
        .force_req  (force_req),
        .force_mode (force_mode),
        .mode       (mode),
        .oc         (oc)
    );

    // Software sees the register it writes: buffer or active value.
    assign cmp_view = dbuf_en ? cmp_buf : cmp_act;

    // Read-back mux by byte address.
    always_comb begin
        case (bus_addr)
            A_CNT_LO: bus_rdata = cnt[BUS_W-1:0];
            A_CNT_HI: bus_rdata = cnt[CNT_W-1:BUS_W];
            A_CMP_LO: bus_rdata = cmp_view[BUS_W-1:0];
            A_CMP_HI: bus_rdata = cmp_view[CNT_W-1:BUS_W];
            A_CTRL:   bus_rdata = {{(BUS_W-2){1'b0}}, mode};
            A_STAT:   bus_rdata = {{(BUS_W-2){1'b0}}, oc, flag};
            default:  bus_rdata = '0;
        endcase
    end

    // Pin pair for the mux: output bit owns the pin when mode is nonzero.
    assign pin_oe  = (mode != OC_HOLD);
    assign pin_val = oc;

endmodule

// File: rtl/ocmp_channel_sva.sv
// Module: assertion checker for the output-compare channel, bound to the top.
module ocmp_channel_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             dbuf_en,
    input logic             cnt_load,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp_act,
    input logic             match_hit,
    input logic             force_req,
    input logic             flag,
    input logic             flag_clr,
    input logic             oc
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_load) |=> (cnt == $past(cnt) + 1'b1)); // R4
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> (cnt == $past(load_val))); // R4
    AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> !match_hit); // R8
    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |=> flag); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag); // R5
    AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (force_req && !match_hit && !flag) |=> !flag); // R7
    AST_OC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_hit && !force_req) |=> $stable(oc)); // R6
    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dbuf_en && !(tick_en && cnt == TOP)) |=> $stable(cmp_act)); // R3

endmodule

bind ocmp_channel ocmp_channel_sva #(.CNT_W(CNT_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .dbuf_en   (dbuf_en),
    .cnt_load  (cnt_load),
    .load_val  (wide_data),
    .cnt       (cnt),
    .cmp_act   (cmp_act),
    .match_hit (match_hit),
    .force_req (force_req),
    .flag      (flag),
    .flag_clr  (flag_clr),
    .oc        (oc)
);

// File: tb/ocmp_channel_test.sv
// Directed bench for ocmp_channel: one task per scenario, each self-checking.
module ocmp_channel_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       dbuf_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       pin_oe;
    logic       pin_val;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ocmp_channel uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .dbuf_en   (dbuf_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_oe    (pin_oe),
        .pin_val   (pin_val)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus write; starts and ends at a falling edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd8(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a; #0.5; v = bus_rdata;
    endtask

    task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
        logic [7:0] b;
        rd8(lo, b); v[7:0] = b;
        rd8(lo + 3'd1, b); v[15:8] = b;
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(3'd1, v[15:8]); wr(3'd0, v[7:0]);
    endtask

    task automatic set_cmp(input logic [15:0] v);
        wr(3'd3, v[15:8]); wr(3'd2, v[7:0]);
    endtask

    // n ticked rising edges, ending at a falling edge.
    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic stat(output logic flag, output logic oc);
        logic [7:0] b;
        rd8(3'd5, b); flag = b[0]; oc = b[1];
    endtask

    task automatic t_reset;
        logic [15:0] v; logic [7:0] b;
        rd16(3'd0, v); check("R1 counter", v, 0);
        rd16(3'd2, v); check("R1 compare", v, 0);
        rd8(3'd4, b);  check("R1 mode", b, 0);
        rd8(3'd5, b);  check("R1 status", b, 0);
        check("R1 pin_oe", pin_oe, 0);
        check("R1 pin_val", pin_val, 0);
    endtask

    task automatic t_cmp_write;
        logic [15:0] v;
        wr(3'd3, 8'h12);
        rd16(3'd2, v); check("R2 high byte alone", v, 16'h0000);
        wr(3'd2, 8'h34);
        rd16(3'd2, v); check("R2 commit", v, 16'h1234);
    endtask

    task automatic t_counter;
        logic [15:0] v;
        set_cnt(16'h0100);
        rd16(3'd0, v); check("R4 load", v, 16'h0100);
        ticks(5);
        rd16(3'd0, v); check("R4 advance", v, 16'h0105);
        tick_en = 1'b1;
        wr(3'd1, 8'h20); wr(3'd0, 8'h00);
        tick_en = 1'b0;
        rd16(3'd0, v); check("R4 load beats tick", v, 16'h2000);
    endtask

    task automatic t_match_modes;
        logic f, o;
        wr(3'd4, 8'h01);
        check("R9 pin_oe on", pin_oe, 1);
        set_cmp(16'h2005);
        ticks(5);
        stat(f, o); check("R5 no early flag", f, 0);
        ticks(1);
        stat(f, o); check("R5 flag on match", f, 1);
        check("R6 toggle", o, 1);
        check("R9 pin_val", pin_val, 1);
        ticks(3);
        stat(f, o); check("R5 flag sticky", f, 1);
        check("R6 single toggle", o, 1);
        wr(3'd5, 8'h01);
        stat(f, o); check("R5 flag clear", f, 0);
        wr(3'd4, 8'h02);
        set_cnt(16'h2003); ticks(3);
        stat(f, o); check("R6 clear", o, 0); wr(3'd5, 8'h01);
        wr(3'd4, 8'h03);
        set_cnt(16'h2003); ticks(3);
        stat(f, o); check("R6 set", o, 1); wr(3'd5, 8'h01);
        wr(3'd4, 8'h00);
        check("R9 pin_oe off", pin_oe, 0);
        stat(f, o); check("R9 oc kept over mode change", o, 1);
        set_cnt(16'h2003); ticks(3);
        stat(f, o); check("R6 hold flag", f, 1); check("R6 hold oc", o, 1);
        wr(3'd5, 8'h01);
    endtask

    task automatic t_force;
        logic [15:0] c0, c1; logic f, o; logic [7:0] b;
        rd16(3'd0, c0);
        wr(3'd4, 8'h81);
        stat(f, o); check("R7 force toggle", o, 0); check("R7 no flag", f, 0);
        rd16(3'd0, c1); check("R7 counter kept", c1, c0);
        wr(3'd4, 8'h83);
        stat(f, o); check("R7 force set", o, 1);
        rd8(3'd4, b); check("R10 ctrl read", b, 8'h03);
        rd8(3'd5, b); check("R10 status read", b, 8'h02);
    endtask

    task automatic t_block;
        logic f, o; logic [15:0] v;
        wr(3'd4, 8'h01);
        set_cnt(16'h2005);
        repeat (3) @(negedge clk);
        stat(f, o); check("R5 no match without tick", f, 0);
        ticks(1);
        stat(f, o); check("R8 blocked flag", f, 0); check("R8 blocked oc", o, 1);
        rd16(3'd0, v); check("R8 counter moved", v, 16'h2006);
        set_cnt(16'h2004); ticks(2);
        stat(f, o); check("R8 later match", f, 1); check("R8 later oc", o, 0);
        wr(3'd5, 8'h01);
    endtask

    task automatic t_dbuf;
        logic f, o; logic [15:0] v;
        dbuf_en = 1'b1;
        set_cmp(16'h3000);
        rd16(3'd2, v); check("R3 buffer readback", v, 16'h3000);
        set_cnt(16'h2003); ticks(3);
        stat(f, o); check("R3 old value active", f, 1); wr(3'd5, 8'h01);
        set_cnt(16'hFFFE); ticks(2);
        rd16(3'd0, v); check("R4 wrap", v, 16'h0000);
        set_cnt(16'h2003); ticks(3);
        stat(f, o); check("R3 old value gone", f, 0);
        set_cnt(16'h2FFE); ticks(3);
        stat(f, o); check("R3 new value active", f, 1); wr(3'd5, 8'h01);
        dbuf_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_cmp_write;
        t_counter;
        t_match_modes;
        t_force;
        t_block;
        t_dbuf;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule